// File: doc/BRIEF.md
# Processor Status Register with Flag Update Logic

This block holds the eight-bit status word of a small eight-bit processor core and works out each new value from the events of one cycle. It takes the operands and result of the ALU together with an operation class and a per-flag write mask. It derives the carry, half-carry, overflow, negative and zero flags for that operation. Only the flags the mask selects are written. The sign flag is recomputed from the negative and overflow flags on every update.

The same register holds the global interrupt enable, which gates a vector of interrupt requests against their individual enables. The enable is cleared when an interrupt is taken, set again by a return strobe, and set or cleared directly by dedicated strobes. A single transfer bit (T) can be loaded from any chosen bit of an operand. Its value can be merged back into an operand at a chosen position on a combinational output. Software may also overwrite the whole register, and that write wins over every other event in the same cycle. The register is not pushed or popped on interrupt entry or return; the surrounding core does that.

Top module: `psr_core`

## Requirements
- R1: After reset the register reads 0, and the global enable and the T bit outputs are both 0.
- R2: The register layout, from bit 7 to bit 0, is: I (global enable), T (transfer bit), H (half carry), S (sign), V (overflow), N (negative), Z (zero), C (carry). The `gie` and `tbit` outputs mirror bits 7 and 6.
- R3: In every cycle the S bit equals N xor V. This also holds after a software write, whose S bit is replaced by the xor of the written N and V.
- R4: `irq_pass` is all zeros while I is 0. While I is 1 it equals `irq_req & irq_en`.
- R5: I is updated by the following strobes, in priority order:
  - `irq_take` or `gie_clr` clears I in the next cycle.
  - Otherwise `irq_ret` or `gie_set` sets it.
  - These strobes change no other bit.
- R6: For class add (`alu_op` = 1), the flags are computed from the operands and the result:
  - C is the carry out of bit 7 and H is the carry out of bit 3.
  - V is set when both operands share a sign that the result does not.
- R7: For class subtract (`alu_op` = 2), the flags are computed as follows:
  - C is the borrow out of bit 7 and H is the borrow out of bit 3.
  - V is set when the operands' signs differ and the result sign differs from the first operand.
- R8: For class logic (`alu_op` = 3), the computed C, H and V are 0.
- R9: For every ALU class, Z is 1 exactly when the 8-bit result is 0, and N equals result bit 7.
- R10: `flag_mask` bit 0 enables the write of C, bit 1 of Z, bit 2 of N, bit 3 of V and bit 4 of H. Flags whose mask bit is 0 keep their value. Class none (`alu_op` = 0) changes no arithmetic flag.
- R11: A `bst_en` strobe loads T with bit `bit_sel` of `xfer_opnd` in the next cycle.
- R12: `bld_out` is `xfer_opnd` with bit `bit_sel` replaced by the current T, combinationally.
- R13: When `sw_we` is 1, the next register value is `sw_wdata` (with S per R3). All interrupt, transfer and ALU events of that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_op | input | 2 | Operation class: 0 none, 1 add, 2 subtract, 3 logic |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result |
| flag_mask | input | 5 | Flag write enables {H,V,N,Z,C} |
| irq_take | input | 1 | Interrupt accepted this cycle |
| irq_ret | input | 1 | Return from interrupt |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| bst_en | input | 1 | Copy selected operand bit into T |
| bit_sel | input | 3 | Bit index for the transfer operations |
| xfer_opnd | input | 8 | Register operand for the transfer operations |
| bld_out | output | 8 | Operand with the selected bit replaced by T |
| sw_we | input | 1 | Whole-register software write |
| sw_wdata | input | 8 | Software write data |
| irq_req | input | NUM_IRQ | Interrupt requests |
| irq_en | input | NUM_IRQ | Individual interrupt enables |
| irq_pass | output | NUM_IRQ | Requests passed by the global enable |
| sreg | output | 8 | Register value |
| gie | output | 1 | Global interrupt enable |
| tbit | output | 1 | Transfer bit |

## Verification
Several of this block's functions can fall in the same cycle. The key case is an ALU flag update together with an interrupt acceptance, since both change the register at the same edge but touch different bits. A software write can also coincide with either of them and must override both. The bench drives directed cycles that raise these together. It then runs long random stretches in which every strobe, the ALU class and the software write are drawn independently. Each cycle the whole register is compared against a behavioural model that applies the stated priority, so a lost update or a wrong winner shows at once.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int SR_W  = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;
  localparam int BIT_T = 6;
  localparam int BIT_I = 7;

  localparam int MSK_C = 0;
  localparam int MSK_Z = 1;
  localparam int MSK_N = 2;
  localparam int MSK_V = 3;
  localparam int MSK_H = 4;
  localparam int MSK_W = 5;

  typedef enum logic [1:0] {
    OPC_NONE  = 2'd0,
    OPC_ADD   = 2'd1,
    OPC_SUB   = 2'd2,
    OPC_LOGIC = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic h;
    logic v;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;

  // carry out of a bit position, recovered from operand and result bits
  function automatic logic add_carry(input logic a, input logic b, input logic r);
    return (a & b) | (b & ~r) | (~r & a);
  endfunction

  // borrow out of a bit position for a - b
  function automatic logic sub_borrow(input logic a, input logic b, input logic r);
    return (~a & b) | (b & r) | (r & ~a);
  endfunction

  function automatic logic add_ovf(input logic a, input logic b, input logic r);
    return (a & b & ~r) | (~a & ~b & r);
  endfunction

  function automatic logic sub_ovf(input logic a, input logic b, input logic r);
    return (a & ~b & ~r) | (~a & b & r);
  endfunction

endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_cls_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW-1:0]   res,
  output arith_flags_t    flags
);
  localparam int MSB  = DW - 1;
  localparam int HALF = DW / 2 - 1;

  logic res_zero;
  assign res_zero = (res == '0);

  always_comb begin
    flags   = '0;
    flags.z = res_zero;
    flags.n = res[MSB];
    unique case (op)
      OPC_ADD: begin
        flags.c = add_carry(a[MSB], b[MSB], res[MSB]);
        flags.h = add_carry(a[HALF], b[HALF], res[HALF]);
        flags.v = add_ovf(a[MSB], b[MSB], res[MSB]);
      end
      OPC_SUB: begin
        flags.c = sub_borrow(a[MSB], b[MSB], res[MSB]);
        flags.h = sub_borrow(a[HALF], b[HALF], res[HALF]);
        flags.v = sub_ovf(a[MSB], b[MSB], res[MSB]);
      end
      default: begin
        flags.c = 1'b0;
        flags.h = 1'b0;
        flags.v = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
  parameter int NUM_IRQ = 4
) (
  input  logic               gie,
  input  logic [NUM_IRQ-1:0] req,
  input  logic [NUM_IRQ-1:0] en,
  output logic [NUM_IRQ-1:0] pass
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign pass[g] = gie & en[g] & req[g];
  end
endmodule

// File: rtl/psr_bit_xfer.sv
module psr_bit_xfer #(
  parameter int DW = 8
) (
  input  logic [$clog2(DW)-1:0] sel,
  input  logic [DW-1:0]         opnd,
  input  logic                  tval,
  output logic                  picked,
  output logic [DW-1:0]         merged
);
  assign picked = opnd[sel];

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign merged[g] = (sel == g[$clog2(DW)-1:0]) ? tval : opnd[g];
  end
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         alu_op,
  input  logic [7:0]         alu_a,
  input  logic [7:0]         alu_b,
  input  logic [7:0]         alu_res,
  input  logic [4:0]         flag_mask,
  input  logic               irq_take,
  input  logic               irq_ret,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               bst_en,
  input  logic [2:0]         bit_sel,
  input  logic [7:0]         xfer_opnd,
  output logic [7:0]         bld_out,
  input  logic               sw_we,
  input  logic [7:0]         sw_wdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic [NUM_IRQ-1:0] irq_pass,
  output logic [7:0]         sreg,
  output logic               gie,
  output logic               tbit
);

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;
  arith_flags_t    calc;
  op_cls_e         opc;
  logic            alu_upd;
  logic            i_clear_evt;
  logic            i_set_evt;
  logic            bst_bit;

  assign opc         = op_cls_e'(alu_op);
  assign alu_upd     = (opc != OPC_NONE);
  assign i_clear_evt = irq_take | gie_clr;
  assign i_set_evt   = (irq_ret | gie_set) & ~i_clear_evt;

  psr_flag_calc #(.DW(SR_W)) u_calc (
    .op    (opc),
    .a     (alu_a),
    .b     (alu_b),
    .res   (alu_res),
    .flags (calc)
  );

  psr_bit_xfer #(.DW(SR_W)) u_xfer (
    .sel    (bit_sel),
    .opnd   (xfer_opnd),
    .tval   (sr_q[BIT_T]),
    .picked (bst_bit),
    .merged (bld_out)
  );

  psr_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .gie  (sr_q[BIT_I]),
    .req  (irq_req),
    .en   (irq_en),
    .pass (irq_pass)
  );

  always_comb begin
    sr_d = sr_q;
    if (sw_we) begin
      sr_d        = sw_wdata;
      sr_d[BIT_S] = sw_wdata[BIT_N] ^ sw_wdata[BIT_V];
    end else begin
      if (i_clear_evt)    sr_d[BIT_I] = 1'b0;
      else if (i_set_evt) sr_d[BIT_I] = 1'b1;
      if (bst_en)         sr_d[BIT_T] = bst_bit;
      if (alu_upd) begin
        if (flag_mask[MSK_C]) sr_d[BIT_C] = calc.c;
        if (flag_mask[MSK_Z]) sr_d[BIT_Z] = calc.z;
        if (flag_mask[MSK_N]) sr_d[BIT_N] = calc.n;
        if (flag_mask[MSK_V]) sr_d[BIT_V] = calc.v;
        if (flag_mask[MSK_H]) sr_d[BIT_H] = calc.h;
      end
      sr_d[BIT_S] = sr_d[BIT_N] ^ sr_d[BIT_V];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sreg = sr_q;
  assign gie  = sr_q[BIT_I];
  assign tbit = sr_q[BIT_T];

endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk #(
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_we,
  input logic [7:0]         sw_wdata,
  input logic               irq_take,
  input logic               irq_ret,
  input logic               gie_set,
  input logic               gie_clr,
  input logic               bst_en,
  input logic [2:0]         bit_sel,
  input logic [7:0]         xfer_opnd,
  input logic [1:0]         alu_op,
  input logic [NUM_IRQ-1:0] irq_pass,
  input logic [7:0]         sreg,
  input logic               gie,
  input logic               tbit,
  input logic               alu_upd
);

  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sreg[4] == (sreg[3] ^ sreg[2]));

  p_gate_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_pass == '0));

  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !sw_we) |=> !sreg[7]);

  p_ret_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_take && !gie_clr && !sw_we) |=> sreg[7]);

  p_none_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_upd && !sw_we) |=> $stable({sreg[5], sreg[3:0]}));

  p_bst_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_en && !sw_we) |=> (tbit == $past(xfer_opnd[bit_sel])));

  p_sw_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> ({sreg[7:5], sreg[3:0]} == {$past(sw_wdata[7:5]), $past(sw_wdata[3:0])}));

  p_op_decoded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alu_upd == (alu_op != 2'd0));

endmodule

bind psr_core psr_core_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/psr_core_test.sv
`timescale 1ns/1ps
module psr_core_test;
  localparam int NIRQ = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      alu_op;
  logic [7:0]      alu_a, alu_b, alu_res;
  logic [4:0]      flag_mask;
  logic            irq_take, irq_ret, gie_set, gie_clr, bst_en;
  logic [2:0]      bit_sel;
  logic [7:0]      xfer_opnd, bld_out;
  logic            sw_we;
  logic [7:0]      sw_wdata;
  logic [NIRQ-1:0] irq_req, irq_en, irq_pass;
  logic [7:0]      sreg;
  logic            gie, tbit;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  psr_core #(.NUM_IRQ(NIRQ)) uut (
    .clk, .rst_n, .alu_op, .alu_a, .alu_b, .alu_res, .flag_mask,
    .irq_take, .irq_ret, .gie_set, .gie_clr, .bst_en, .bit_sel,
    .xfer_opnd, .bld_out, .sw_we, .sw_wdata, .irq_req, .irq_en,
    .irq_pass, .sreg, .gie, .tbit
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_op = 0; alu_a = 0; alu_b = 0; alu_res = 0; flag_mask = 0;
    irq_take = 0; irq_ret = 0; gie_set = 0; gie_clr = 0; bst_en = 0;
    bit_sel = 0; xfer_opnd = 0; sw_we = 0; sw_wdata = 0;
  endtask

  // behavioural expectation of the next register value
  function automatic logic [7:0] predict();
    logic [7:0] m = model;
    int a = alu_a, b = alu_b, r, cin, sa, sb, sr;
    logic c = 0, h = 0, v = 0;
    if (sw_we) begin
      m = sw_wdata;
      m[4] = m[2] ^ m[3];
      return m;
    end
    if (irq_take || gie_clr) m[7] = 0;
    else if (irq_ret || gie_set) m[7] = 1;
    if (bst_en) m[6] = xfer_opnd[bit_sel];
    if (alu_op != 0) begin
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      if (alu_op == 1) begin
        cin = (alu_res - a - b) & 1;
        c = (a + b + cin) > 255;
        h = ((a % 16) + (b % 16) + cin) > 15;
        sr = sa + sb + cin;
        v = (sr > 127) || (sr < -128);
      end else if (alu_op == 2) begin
        cin = (a - b - alu_res) & 1;
        c = a < (b + cin);
        h = (a % 16) < ((b % 16) + cin);
        sr = sa - sb - cin;
        v = (sr > 127) || (sr < -128);
      end
      r = alu_res;
      if (flag_mask[0]) m[0] = c;
      if (flag_mask[1]) m[1] = (r == 0);
      if (flag_mask[2]) m[2] = alu_res[7];
      if (flag_mask[3]) m[3] = v;
      if (flag_mask[4]) m[5] = h;
    end
    m[4] = m[2] ^ m[3];
    return m;
  endfunction

  // one clock: combinational checks, edge, then register comparison
  task automatic tick(input string tag);
    logic [7:0] want_bld;
    #1;
    chk("R4", irq_pass, model[7] ? (irq_req & irq_en) : '0);
    want_bld = xfer_opnd;
    want_bld[bit_sel] = model[6];
    chk("R12", bld_out, want_bld);
    model = predict();
    @(negedge clk);
    chk(tag, sreg, model);
    chk("R3", sreg[4], sreg[3] ^ sreg[2]);
  endtask

  task automatic arith(input logic [1:0] op, input int a, input int b, input int cin, input logic [4:0] mk);
    alu_op = op; alu_a = a[7:0]; alu_b = b[7:0]; flag_mask = mk;
    alu_res = (op == 1) ? 8'(a + b + cin) : 8'(a - b - cin);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    irq_req = 0; irq_en = 0;
    repeat (3) @(negedge clk);
    chk("R1", {sreg, gie, tbit}, 10'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", sreg, 8'h00);

    // R2 layout through software writes
    sw_we = 1; sw_wdata = 8'h40; tick("R13"); idle();
    chk("R2", {gie, tbit}, 2'b01);
    sw_we = 1; sw_wdata = 8'h80; tick("R13"); idle();
    chk("R2", {gie, tbit}, 2'b10);
    sw_we = 1; sw_wdata = 8'h1C; tick("R13"); idle();
    chk("R3", sreg, 8'h0C);
    sw_we = 1; sw_wdata = 8'h84; tick("R13"); idle();
    chk("R3", sreg, 8'h94);

    // R4 gate open then closed
    irq_req = 4'b1011; irq_en = 4'b0110; tick("R4");
    chk("R4", irq_pass, 4'b0010);

    // R5 interrupt enable events and priority
    irq_take = 1; gie_set = 1; tick("R5"); idle();
    chk("R5", gie, 1'b0);
    chk("R4", irq_pass, 4'b0000);
    irq_ret = 1; tick("R5"); idle();
    chk("R5", gie, 1'b1);
    gie_clr = 1; irq_ret = 1; tick("R5"); idle();
    chk("R5", gie, 1'b0);
    gie_set = 1; tick("R5"); idle();
    chk("R5", gie, 1'b1);

    // interrupt acceptance together with an ALU update in one cycle
    irq_take = 1; arith(2'd1, 8'h80, 8'h80, 0, 5'h1F); tick("R5"); idle();
    chk("R6", sreg, 8'h1B);

    // R6 half carry and carry
    arith(2'd1, 8'h0F, 8'h01, 0, 5'h1F); tick("R6"); idle();
    chk("R6", sreg[5], 1'b1);
    arith(2'd1, 8'h7F, 8'h01, 0, 5'h1F); tick("R6"); idle();
    chk("R6", sreg[3:0], 4'b1100);

    // R7 subtract borrows
    arith(2'd2, 8'h00, 8'h01, 0, 5'h1F); tick("R7"); idle();
    chk("R7", {sreg[5], sreg[3:0]}, 5'b1_0101);
    arith(2'd2, 8'h80, 8'h01, 0, 5'h1F); tick("R7"); idle();
    chk("R7", sreg[3], 1'b1);

    // R8 / R9 logic class
    alu_op = 3; alu_res = 8'h00; flag_mask = 5'h1F; tick("R8"); idle();
    chk("R9", sreg[5:0], 6'b000010);
    alu_op = 3; alu_res = 8'hF0; flag_mask = 5'h1F; tick("R9"); idle();
    chk("R9", sreg[2:1], 2'b10);

    // R10 masking and class none
    alu_op = 0; alu_res = 8'h00; flag_mask = 5'h1F; tick("R10"); idle();
    chk("R10", sreg[2:1], 2'b10);
    arith(2'd1, 8'h00, 8'h00, 0, 5'b00010); tick("R10"); idle();
    chk("R10", sreg[2:1], 2'b11);

    // R11 / R12 transfer bit
    bst_en = 1; xfer_opnd = 8'h20; bit_sel = 5; tick("R11"); idle();
    chk("R11", tbit, 1'b1);
    xfer_opnd = 8'h00; bit_sel = 2; #1;
    chk("R12", bld_out, 8'h04);
    tick("R12");
    bst_en = 1; xfer_opnd = 8'hDF; bit_sel = 5; tick("R11"); idle();
    chk("R11", tbit, 1'b0);

    // R13 software write beats everything in the same cycle
    sw_we = 1; sw_wdata = 8'h08; irq_take = 1; gie_set = 1; bst_en = 1;
    xfer_opnd = 8'hFF; bit_sel = 6; arith(2'd1, 8'hFF, 8'h01, 0, 5'h1F);
    tick("R13"); idle();
    chk("R13", sreg, 8'h18);

    // random add/subtract against the model
    for (int i = 0; i < 400; i++) begin
      arith(($urandom % 2) ? 2'd1 : 2'd2, $urandom % 256, $urandom % 256, $urandom % 2, 5'h1F);
      tick((alu_op == 1) ? "R6" : "R7");
    end
    idle();

    // random mixture of every event
    for (int i = 0; i < 800; i++) begin
      arith(2'($urandom), $urandom % 256, $urandom % 256, $urandom % 2, 5'($urandom));
      if (alu_op == 3) alu_res = 8'($urandom);
      irq_take  = ($urandom % 6) == 0;
      irq_ret   = ($urandom % 5) == 0;
      gie_set   = ($urandom % 5) == 0;
      gie_clr   = ($urandom % 6) == 0;
      bst_en    = ($urandom % 3) == 0;
      bit_sel   = 3'($urandom);
      xfer_opnd = 8'($urandom);
      sw_we     = ($urandom % 8) == 0;
      sw_wdata  = 8'($urandom);
      irq_req   = NIRQ'($urandom);
      irq_en    = NIRQ'($urandom);
      tick(sw_we ? "R13" : "R10");
    end
    idle();
    tick("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule